// File: doc/BRIEF.md
# Activity Watchdog With Line Selection

This block supervises a host processor by watching a single digital line for signs of life. A static select chooses the watched line: either a dedicated watchdog strobe input or the serial data line of the board's two-wire bus. Every change of level on the watched line, upward or downward, restarts an idle counter. If the line stays at one level for a full interval of `TIMEOUT_CYCLES` clock cycles, the block raises a single-cycle timeout request. A separate reset sequencer turns that request into a stretched system reset.

While the system reset is active, the counter is held at zero and cannot fire, so a processor that is still booting cannot be punished. The watched line is synchronized into the clock domain before edge detection. A change that lands in the same cycle as an expiry wins, and no request is raised. The default interval is 1.6 s at 100 MHz.

Top module: `act_wdog`

## Requirements
- R1: While `rst_ni` is low, `timeout_o` is low and the idle counter is zero. This holds asynchronously, and the first expiry after release comes `TIMEOUT_CYCLES` clock edges later when the line is quiet.
- R2: `line_sel_i` = 0 watches `wdi_i` and `line_sel_i` = 1 watches `sda_i`. Level changes on the line that is not selected have no effect on `timeout_o`.
- R3: A rising change and a falling change on the watched line each clear the idle counter.
- R4: A change on the watched line is first sampled at clock edge 1. With `SYNC_STAGES` = S and `TIMEOUT_CYCLES` = T and no further change, `timeout_o` is high after edge 1+S+T and at no earlier edge.
- R5: `timeout_o` is high for exactly one clock cycle per expiry.
- R6: While `sys_rst_i` is high, the counter stays at zero and `timeout_o` stays low. After `sys_rst_i` falls (first low at edge 1), `timeout_o` is high after edge T if the line is quiet.
- R7: If a change on the watched line clears the counter at the same edge at which it would expire, no request is raised for that interval.
- R8: After firing, the counter restarts from zero. On a quiet line, requests therefore repeat exactly every T cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sys_rst_i | input | 1 | System reset active (synchronous); holds the counter cleared |
| line_sel_i | input | 1 | Static line select: 0 = wdi_i, 1 = sda_i |
| wdi_i | input | 1 | Dedicated watchdog strobe (asynchronous) |
| sda_i | input | 1 | Serial data line (asynchronous) |
| timeout_o | output | 1 | One-cycle timeout request to the reset sequencer |

## Verification
A line change reaches the counter clear after S synchronizer edges. The expiry is registered, so the request follows a change by 1+S+T edges and follows a release of `sys_rst_i` by T edges. The bench drives inputs 2 ns after a rising edge and samples `timeout_o` at the same offset after each following edge. It compares each cycle against the arithmetically expected pulse edges. The sweep places a second change at every gap from 1 to T+4 cycles after a first change, for both select values, while the unselected line toggles every cycle. This covers early clears, the exact expiry-coincidence edge and the gaps that let the first interval fire.

// File: rtl/act_wdog_pkg.sv
package act_wdog_pkg;
  typedef enum logic {
    LINE_WDI = 1'b0,
    LINE_SDA = 1'b1
  } line_sel_e;
endpackage

// File: rtl/act_wdog_sync.sv
module act_wdog_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) chain_q <= '0;
        else         chain_q <= d_i;
    end else begin : g_many
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) chain_q <= '0;
        else         chain_q <= {chain_q[STAGES-2:0], d_i};
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/act_wdog_edge.sv
module act_wdog_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic s_i,
  output logic edge_o
);
  logic prev_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= s_i;

  // either direction counts as activity
  assign edge_o = s_i ^ prev_q;
endmodule

// File: rtl/act_wdog_cnt.sv
module act_wdog_cnt #(
  parameter int LIMIT = 160_000_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hold_i,
  input  logic clear_i,
  output logic fire_o
);
  localparam int CW = (LIMIT > 2) ? $clog2(LIMIT) : 1;
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q;
  logic          fire_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      fire_q <= 1'b0;
    end else if (hold_i || clear_i) begin
      // activity wins over a coincident expiry
      cnt_q  <= '0;
      fire_q <= 1'b0;
    end else if (cnt_q == LAST) begin
      cnt_q  <= '0;
      fire_q <= 1'b1;
    end else begin
      cnt_q  <= cnt_q + 1'b1;
      fire_q <= 1'b0;
    end
  end

  assign fire_o = fire_q;

  // R6
  hold_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_i |=> (cnt_q == '0 && !fire_q));

  // R8
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);

  // R8
  restart_after_fire_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_q |-> cnt_q == '0);

  // R5
  single_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_q |=> !fire_q);
endmodule

// File: rtl/act_wdog.sv
module act_wdog
  import act_wdog_pkg::*;
#(
  parameter int TIMEOUT_CYCLES = 160_000_000,
  parameter int SYNC_STAGES    = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sys_rst_i,
  input  logic line_sel_i,
  input  logic wdi_i,
  input  logic sda_i,
  output logic timeout_o
);
  line_sel_e sel;
  logic      raw_line;
  logic      sync_line;
  logic      activity;

  assign sel      = line_sel_e'(line_sel_i);
  // select is static, so muxing ahead of the synchronizer is safe
  assign raw_line = (sel == LINE_SDA) ? sda_i : wdi_i;

  act_wdog_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw_line),
    .q_o   (sync_line)
  );

  act_wdog_edge u_edge (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .s_i   (sync_line),
    .edge_o(activity)
  );

  act_wdog_cnt #(.LIMIT(TIMEOUT_CYCLES)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .hold_i (sys_rst_i),
    .clear_i(activity),
    .fire_o (timeout_o)
  );

  // R7
  edge_suppresses_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |-> !$past(activity));

  // R6
  no_fire_in_reset_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |-> !$past(sys_rst_i));

  // R1
  always_comb
    if (!rst_ni) reset_quiet_chk: assert (!timeout_o || $isunknown(timeout_o));
endmodule

// File: tb/act_wdog_bench.sv
module act_wdog_bench;
  localparam int T = 12;
  localparam int S = 2;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic sys_rst_i = 1'b1;
  logic line_sel_i = 1'b0;
  logic wdi_i = 1'b0;
  logic sda_i = 1'b0;
  logic timeout_o;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  act_wdog #(.TIMEOUT_CYCLES(T), .SYNC_STAGES(S)) u_act_wdog (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sys_rst_i (sys_rst_i),
    .line_sel_i(line_sel_i),
    .wdi_i     (wdi_i),
    .sda_i     (sda_i),
    .timeout_o (timeout_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk_i);
    #2;
  endtask

  task automatic tog(input bit on_sda);
    if (on_sda) sda_i = ~sda_i;
    else        wdi_i = ~wdi_i;
  endtask

  initial begin
    // R1: reset state
    tick;
    chk(timeout_o === 1'b0, "R1 reset", int'(timeout_o), 0);
    rst_ni = 1'b1;

    // R2 R3 R4 R7: second change swept over every gap, both selects
    for (int sel = 0; sel < 2; sel++) begin
      for (int g = 1; g <= T + 4; g++) begin
        bit bad = 1'b0;
        int bad_n = 0;
        int bad_act = 0;
        sys_rst_i  = 1'b1;
        line_sel_i = sel[0];
        repeat (S + 2) tick;
        sys_rst_i = 1'b0;
        tog(sel[0]);
        for (int n = 1; n <= 1 + g + S + T + 3; n++) begin
          bit exp;
          if (n == 1 + g) tog(sel[0]);
          tog(!sel[0]);
          tick;
          exp = (g > T && n == 1 + S + T) || (n == 1 + g + S + T);
          if (timeout_o !== exp && !bad) begin
            bad = 1'b1;
            bad_n = n;
            bad_act = int'(timeout_o);
          end
        end
        if (g == T)
          chk(!bad, $sformatf("R7 sel=%0d gap=%0d edge=%0d", sel, g, bad_n), bad_act, 1 - bad_act);
        else
          chk(!bad, $sformatf("R2 R3 R4 sel=%0d gap=%0d edge=%0d", sel, g, bad_n), bad_act, 1 - bad_act);
      end
    end

    // R6: held in system reset, no request
    begin
      int seen = 0;
      sys_rst_i = 1'b1;
      repeat (3 * T) begin
        tick;
        if (timeout_o) seen++;
      end
      chk(seen == 0, "R6 hold", seen, 0);
    end

    // R6 R8 R5: release, then periodic single-cycle requests
    begin
      bit bad = 1'b0;
      int bad_n = 0;
      sys_rst_i = 1'b0;
      for (int n = 1; n <= 2 * T + 1; n++) begin
        tick;
        if (timeout_o !== ((n == T) || (n == 2 * T)) && !bad) begin
          bad = 1'b1;
          bad_n = n;
        end
      end
      chk(!bad, "R6 R8 R5 release/periodic", bad_n, 0);
    end

    // R6: system reset in mid-count restarts the interval
    begin
      bit bad = 1'b0;
      int bad_n = 0;
      repeat (5) tick;
      sys_rst_i = 1'b1;
      repeat (2) tick;
      sys_rst_i = 1'b0;
      for (int n = 1; n <= T + 2; n++) begin
        tick;
        if (timeout_o !== (n == T) && !bad) begin
          bad = 1'b1;
          bad_n = n;
        end
      end
      chk(!bad, "R6 mid-count", bad_n, 0);
    end

    // R1: async reset in mid-count
    begin
      bit bad = 1'b0;
      int bad_n = 0;
      sys_rst_i = 1'b1;
      wdi_i = 1'b0;
      sda_i = 1'b0;
      repeat (S + 2) tick;
      sys_rst_i = 1'b0;
      repeat (4) tick;
      rst_ni = 1'b0;
      #1;
      chk(timeout_o === 1'b0, "R1 async", int'(timeout_o), 0);
      tick;
      rst_ni = 1'b1;
      for (int n = 1; n <= T + 1; n++) begin
        tick;
        if (timeout_o !== (n == T) && !bad) begin
          bad = 1'b1;
          bad_n = n;
        end
      end
      chk(!bad, "R1 restart", bad_n, 0);
    end

    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      done = 1'b1;
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule